// File: doc/BRIEF.md
# Frame Acquire Sequencer

This block decides when the frame store may be written while one video frame is grabbed. The host sets an acquire control bit to arm a grab. Nothing is written at that moment. Writing is enabled at the next rising edge of vertical blanking and stays enabled across two complete fields. It ends when the second blanking period after the start begins, so one whole interlaced frame is captured. The block then holds a completed state and shows the stored picture until the host drops the acquire bit.

The vertical blank input comes from the video timing and is resynchronised through a parameterised flop chain. A registered copy of the synchronised level yields a single-cycle start-of-blank pulse, which is the only event that advances the capture. The display-source select follows the host's stored-video bit while the block is idle. It forces live video while a grab is armed or in progress, and it forces stored video once the grab completes. A status byte reports the synchronised blanking level together with a one-hot view of the sequencer's state, so the host can wait for a 0-to-1 change of the blank bit.

States: IDLE, ARMED, CAP_FIELD1, CAP_FIELD2, DONE. Transitions: IDLE to ARMED when acquire is set. ARMED to IDLE when acquire is cleared (cancel, which takes priority). ARMED to CAP_FIELD1 on a blank edge. CAP_FIELD1 to CAP_FIELD2 on a blank edge. CAP_FIELD2 to DONE on a blank edge. DONE to IDLE when acquire is cleared.

Top module: `frame_acq_seq`

## Requirements
- R1: After reset the block is in IDLE: `cap_en_o` is 0, `disp_stored_o` is 0 and status bits 4..1 are 0. Status bits 4..1 are never more than one-hot.
- R2: In IDLE, `disp_stored_o` equals the value `show_stored_i` had at the previous rising clock edge (1 = stored frame, 0 = live video).
- R3: Setting `acq_req_i` in IDLE sets status bit 1 (armed) one cycle later. `cap_en_o` remains 0 for as long as no vertical blank rising edge arrives.
- R4: While armed, `cap_en_o` goes to 1 on the (SYNC_STAGES+1)-th rising clock edge after `vblank_i` rises. Without a blank edge, `cap_en_o` never rises.
- R5: Capture is split into two fields, shown by status bit 2 (field 1) and status bit 3 (field 2). `cap_en_o` stays 1 through the first following blank edge and falls when the second following blank edge is detected. At that point the block enters DONE, shown by status bit 4.
- R6: Clearing `acq_req_i` during capture does not shorten it. `cap_en_o` stays 1 until the blank edges of R5 have occurred.
- R7: Clearing `acq_req_i` while armed returns the block to IDLE on the next cycle. Later blank edges then leave `cap_en_o` at 0.
- R8: In DONE, `disp_stored_o` is 1 whatever `show_stored_i` is. DONE holds while `acq_req_i` is 1. When `acq_req_i` is cleared the block returns to IDLE.
- R9: While armed or capturing, `disp_stored_o` is 0 (live video).
- R10: Status bit 0 equals `vblank_i` delayed by SYNC_STAGES clock edges. Status bits 7..5 read 0.
- R11: A blank level held high counts as a single edge. Only a new 0-to-1 change of the blank level advances the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req_i | input | 1 | Acquire control bit from the host register file |
| show_stored_i | input | 1 | Stored-video display bit from the host register file |
| vblank_i | input | 1 | Vertical blank level from the video timing, asynchronous |
| cap_en_o | output | 1 | Write enable to the frame store write path |
| disp_stored_o | output | 1 | Display source: 1 stored frame, 0 live video |
| status_o | output | STATUS_W | [0] blank, [1] armed, [2] field 1, [3] field 2, [4] done, rest 0 |

## Verification
The status byte mirrors the state one-hot, so a wrong state shows at the ports on the cycle after the faulty transition. `cap_en_o` and `disp_stored_o` expose the same fault in that cycle. A miscounted or missed blank edge appears at the end of the affected blank pulse: `cap_en_o` is then high or low one field too early or too late. An edge detector that reacts to the blank level rather than its rise shows up during a long blank pulse, when the field bits advance more than once.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_CAP1   = 3'd2,
        ST_CAP2   = 3'd3,
        ST_DONE   = 3'd4
    } acq_state_e;

    // status byte bit positions (host software decodes these)
    localparam int unsigned STB_VBLANK = 0;
    localparam int unsigned STB_ARMED  = 1;
    localparam int unsigned STB_FIELD1 = 2;
    localparam int unsigned STB_FIELD2 = 3;
    localparam int unsigned STB_DONE   = 4;
    localparam int unsigned STB_USED   = 5;

endpackage

// File: rtl/acq_vb_edge.sv
module acq_vb_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vb_async_i,
    output logic vb_sync_o,
    output logic vb_rise_o
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   vb_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= vb_async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], vb_async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) vb_prev <= 1'b0;
        else        vb_prev <= chain[SYNC_STAGES-1];
    end

    assign vb_sync_o = chain[SYNC_STAGES-1];
    assign vb_rise_o = chain[SYNC_STAGES-1] & ~vb_prev;

endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
    import acq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acq_req_i,
    input  logic       show_stored_i,
    input  logic       vb_rise_i,
    output acq_state_e state_o,
    output logic       cap_en_o,
    output logic       disp_stored_o
);

    acq_state_e state_q;
    acq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acq_req_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!acq_req_i)     state_d = ST_IDLE;
                else if (vb_rise_i) state_d = ST_CAP1;
            end
            ST_CAP1: begin
                if (vb_rise_i) state_d = ST_CAP2;
            end
            ST_CAP2: begin
                if (vb_rise_i) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (!acq_req_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs registered from the next state so they line up with state_q
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en_o      <= 1'b0;
            disp_stored_o <= 1'b0;
        end else begin
            unique case (state_d)
                ST_IDLE: begin
                    cap_en_o      <= 1'b0;
                    disp_stored_o <= show_stored_i;
                end
                ST_ARMED: begin
                    cap_en_o      <= 1'b0;
                    disp_stored_o <= 1'b0;
                end
                ST_CAP1, ST_CAP2: begin
                    cap_en_o      <= 1'b1;
                    disp_stored_o <= 1'b0;
                end
                ST_DONE: begin
                    cap_en_o      <= 1'b0;
                    disp_stored_o <= 1'b1;
                end
                default: begin
                    cap_en_o      <= 1'b0;
                    disp_stored_o <= 1'b0;
                end
            endcase
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/acq_status_pack.sv
module acq_status_pack
    import acq_seq_pkg::*;
#(
    parameter int unsigned STATUS_W = 8
) (
    input  acq_state_e          state_i,
    input  logic                vb_sync_i,
    output logic [STATUS_W-1:0] status_o
);

    always_comb begin
        status_o             = '0;
        status_o[STB_VBLANK] = vb_sync_i;
        status_o[STB_ARMED]  = (state_i == ST_ARMED);
        status_o[STB_FIELD1] = (state_i == ST_CAP1);
        status_o[STB_FIELD2] = (state_i == ST_CAP2);
        status_o[STB_DONE]   = (state_i == ST_DONE);
    end

endmodule

// File: rtl/frame_acq_seq.sv
module frame_acq_seq
    import acq_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned STATUS_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acq_req_i,
    input  logic                show_stored_i,
    input  logic                vblank_i,
    output logic                cap_en_o,
    output logic                disp_stored_o,
    output logic [STATUS_W-1:0] status_o
);

    localparam int unsigned MIN_STATUS_W = STB_USED;

    logic       vb_sync;
    logic       vb_rise;
    acq_state_e state;

    generate
        if (STATUS_W < MIN_STATUS_W || SYNC_STAGES < 1) begin : g_bad_cfg
            initial $error("frame_acq_seq: STATUS_W or SYNC_STAGES too small");
        end
    endgenerate

    acq_vb_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .vb_async_i (vblank_i),
        .vb_sync_o  (vb_sync),
        .vb_rise_o  (vb_rise)
    );

    acq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .acq_req_i     (acq_req_i),
        .show_stored_i (show_stored_i),
        .vb_rise_i     (vb_rise),
        .state_o       (state),
        .cap_en_o      (cap_en_o),
        .disp_stored_o (disp_stored_o)
    );

    acq_status_pack #(
        .STATUS_W (STATUS_W)
    ) u_status (
        .state_i   (state),
        .vb_sync_i (vb_sync),
        .status_o  (status_o)
    );

endmodule

// File: rtl/acq_seq_checker.sv
module acq_seq_checker
    import acq_seq_pkg::*;
#(
    parameter int unsigned STATUS_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acq_req_i,
    input logic                vb_rise,
    input logic                cap_en_o,
    input logic                disp_stored_o,
    input logic [STATUS_W-1:0] status_o
);

    // R1: state view never more than one-hot
    p_state_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_o[STB_DONE:STB_ARMED]));

    // R4: capture cannot start without a detected blank edge
    p_cap_needs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_o && !vb_rise) |=> !cap_en_o);

    // R6: capture cannot end without a detected blank edge
    p_cap_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_o && !vb_rise) |=> cap_en_o);

    // R7: cancel while armed returns to idle
    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[STB_ARMED] && !acq_req_i) |=> (!status_o[STB_ARMED] && !cap_en_o));

    // R8: done shows the stored frame and holds while acquire stays set
    p_done_stored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STB_DONE] |-> disp_stored_o);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[STB_DONE] && acq_req_i) |=> status_o[STB_DONE]);

    // R9: live video while armed or capturing
    p_live_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[STB_ARMED] || cap_en_o) |-> !disp_stored_o);

endmodule

bind frame_acq_seq acq_seq_checker #(
    .STATUS_W (STATUS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acq_req_i     (acq_req_i),
    .vb_rise       (vb_rise),
    .cap_en_o      (cap_en_o),
    .disp_stored_o (disp_stored_o),
    .status_o      (status_o)
);

// File: tb/tb_frame_acq_seq.sv
`timescale 1ns/1ps
module tb_frame_acq_seq;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acq = 1'b0;
    logic       show = 1'b0;
    logic       vb = 1'b0;
    logic       cap_en;
    logic       disp;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    frame_acq_seq #(.SYNC_STAGES(SYNC), .STATUS_W(8)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .acq_req_i     (acq),
        .show_stored_i (show),
        .vblank_i      (vb),
        .cap_en_o      (cap_en),
        .disp_stored_o (disp),
        .status_o      (status)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic vb_pulse(input int hi, input int lo);
        vb = 1'b1;
        cycles(hi);
        vb = 1'b0;
        cycles(lo);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acq = 1'b0; show = 1'b0; vb = 1'b0;
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "cap_en after reset", cap_en, 0);
        chk("R1", "disp after reset", disp, 0);
        chk("R1", "state bits after reset", status[4:1], 0);
    endtask

    task automatic t_idle_display();
        show = 1'b1; cycles(1);
        chk("R2", "idle disp follows 1", disp, 1);
        show = 1'b0; cycles(1);
        chk("R2", "idle disp follows 0", disp, 0);
    endtask

    task automatic t_full_grab();
        show = 1'b1; cycles(2);
        acq = 1'b1; cycles(1);
        chk("R3", "armed bit", status[1], 1);
        chk("R3", "no capture when armed", cap_en, 0);
        chk("R9", "live while armed", disp, 0);
        cycles(20);
        chk("R3", "still no capture without blank", cap_en, 0);
        vb_pulse(6, 6);
        chk("R5", "field1 capture", cap_en, 1);
        chk("R5", "field1 bit", status[2], 1);
        chk("R9", "live while capturing", disp, 0);
        vb_pulse(6, 6);
        chk("R5", "field2 capture", cap_en, 1);
        chk("R5", "field2 bit", status[3], 1);
        vb_pulse(6, 6);
        chk("R5", "capture ends at second blank", cap_en, 0);
        chk("R5", "done bit", status[4], 1);
        chk("R8", "done shows stored", disp, 1);
        show = 1'b0; cycles(5);
        chk("R8", "done ignores show_stored", disp, 1);
        chk("R8", "done holds", status[4], 1);
        acq = 1'b0; cycles(1);
        chk("R8", "idle after acquire clear", status[4:1], 0);
        cycles(1);
        chk("R8", "idle display follows bit again", disp, 0);
    endtask

    task automatic t_drop_mid_capture();
        acq = 1'b1; cycles(2);
        vb_pulse(6, 6);
        chk("R6", "capturing before drop", cap_en, 1);
        acq = 1'b0; cycles(3);
        chk("R6", "capture continues after drop", cap_en, 1);
        vb_pulse(6, 6);
        chk("R6", "still capturing field2", status[3], 1);
        vb_pulse(6, 6);
        chk("R6", "capture ended", cap_en, 0);
        chk("R6", "returned idle", status[4:1], 0);
    endtask

    task automatic t_cancel();
        acq = 1'b1; cycles(3);
        acq = 1'b0; cycles(1);
        chk("R7", "cancel to idle", status[4:1], 0);
        vb_pulse(6, 6);
        vb_pulse(6, 6);
        chk("R7", "no capture after cancel", cap_en, 0);
        chk("R7", "still idle", status[4:1], 0);
    endtask

    task automatic t_latency();
        acq = 1'b1; cycles(2);
        vb = 1'b1; cycles(1);
        chk("R10", "blank bit one edge", status[0], 0);
        chk("R4", "cap after 1 edge", cap_en, 0);
        cycles(1);
        chk("R10", "blank bit after sync", status[0], 1);
        chk("R4", "cap after 2 edges", cap_en, 0);
        cycles(1);
        chk("R4", "cap after 3 edges", cap_en, 1);
        chk("R10", "upper status zero", status[7:5], 0);
        // R11: hold blank high for a long time: only one edge
        cycles(30);
        chk("R11", "held blank stays in field1", status[2], 1);
        vb = 1'b0; cycles(2);
        chk("R10", "blank bit clears", status[0], 0);
        cycles(4);
        vb_pulse(6, 6);
        vb_pulse(6, 6);
        chk("R11", "done after two more edges", status[4], 1);
        acq = 1'b0; cycles(2);
    endtask

    initial begin
        t_reset();
        t_idle_display();
        t_full_grab();
        t_drop_mid_capture();
        t_cancel();
        t_latency();
        done_flag = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done_flag && n < 100000) begin
            @(posedge clk);
            n++;
        end
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule